// File: doc/BRIEF.md
# Protection region configuration register file

This block holds the configuration of a small memory protection unit. It has a read-only capability word, a three-bit control word, a region selector, and a base and an attribute word for each region. Up to sixteen regions are supported. Software reaches all of these through a simple word-wide register port. A write takes effect on the next clock edge, and a read returns data in the same cycle from the word offset on the address lines.

The stored base and attribute values of every region, and the control bits, are driven out as flat vectors. An access checker next to the block reads them. The base and attribute words are always those of the region named by the selector. Three extra pairs of offsets reach that same pair of words, so a loader can stream several regions with back-to-back writes. A base write with its valid flag set moves the selector to the region carried in the low bits of the written word. It then loads that region's base.

Word offsets: 0 capability, 1 control, 2 selector, 3 base, 4 attribute, 5/6, 7/8 and 9/10 the alias pairs (base at the odd offset, attribute at the even one). Offsets 11 to 15 are unmapped.

Top module: `prot_cfg_regs`

## Requirements
- R1: The capability word at offset 0 reads the region count in bits [15:8]. All its other bits, including [23:16] and bit 0, read zero. Writes to it have no effect.
- R2: The control word at offset 1 keeps bits [2:0] (bit 0 unit on, bit 1 checking in fault and masked handlers, bit 2 privileged background map) and reads zero elsewhere. It appears on `cfg_ctrl`.
- R3: The selector at offset 2 stores an 8-bit region number in bits [7:0] and reads zero above them.
- R4: A base write with bit 4 clear loads bits [31:5] into the selected region. A base read returns that region's address in [31:5], zero in bit 4 and the selector's low four bits in [3:0].
- R5: A base write with bit 4 set first loads the selector with bits [3:0], zero-extended. It then stores bits [31:5] into that region.
- R6: The attribute word keeps only the bits under mask 0x173F_FF3F: execute-never in bit 28, permission in [26:24], type extension in [21:19], shareable, cacheable and bufferable in bits 18..16, subregion disables in [15:8], size in [5:1] and enable in bit 0. Every other bit reads zero.
- R7: Offsets 5, 7 and 9 act exactly as the base offset 3, and offsets 6, 8 and 10 act exactly as the attribute offset 4, all on the selected region.
- R8: Region r drives its address on `cfg_base[r*27 +: 27]` and its attribute word on `cfg_attr[r*32 +: 32]`.
- R9: A selector write naming a region at or above the region count, or a valid-flag base write naming one, is ignored: the selector and all bases keep their values.
- R10: Reset clears the control word, the selector and the enable bit of every region (bit r*32 of `cfg_attr`).
- R11: Offsets 11 to 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, same cycle |
| cfg_ctrl | output | 3 | Control bits |
| cfg_base | output | NUM_REGIONS*27 | Flat region base addresses |
| cfg_attr | output | NUM_REGIONS*32 | Flat region attribute words |

## Verification
The assertions assume that `bus_wen` and `bus_addr` are known and stable around each rising edge. They also assume at most one write per cycle, and that reset is held for at least one edge before any access. The bench drives every input on the falling edge and pulses the write strobe for exactly one cycle. It starts with reset asserted from time zero, so each property sees legal traffic only. The stimulus sweeps every region through every alias pair. It also tries every selector value up to 15 and some above, so both the legal range and the ignored range are exercised.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

  localparam int DATA_W = 32;
  localparam int BASE_W = 27;
  localparam int SEL_W  = 8;

  // Fixed word offsets; aliases follow as base + 2k / attr + 2k.
  localparam int OFF_CAP  = 0;
  localparam int OFF_CTRL = 1;
  localparam int OFF_SEL  = 2;
  localparam int OFF_BASE = 3;
  localparam int OFF_ATTR = 4;

  // Implemented attribute bits.
  localparam logic [DATA_W-1:0] ATTR_KEEP = 32'h173F_FF3F;

  function automatic logic [DATA_W-1:0] cap_word(int unsigned regions);
    logic [7:0] cnt;
    cnt = 8'(regions);
    return {16'h0000, cnt, 8'h00};
  endfunction

  function automatic logic [DATA_W-1:0] base_word(logic [BASE_W-1:0] addr,
                                                  logic [SEL_W-1:0]  sel);
    return {addr, 1'b0, sel[3:0]};
  endfunction

  function automatic logic region_ok(logic [SEL_W-1:0] r, int unsigned regions);
    return 32'(r) < regions;
  endfunction

endpackage

// File: rtl/prot_cfg_decode.sv
module prot_cfg_decode
  import prot_cfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_ALIAS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cap,
  output logic              hit_ctrl,
  output logic              hit_sel,
  output logic              hit_base,
  output logic              hit_attr
);
  localparam int PAIRS = NUM_ALIAS + 1;

  logic [PAIRS-1:0] base_m;
  logic [PAIRS-1:0] attr_m;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign base_m[k] = (addr == ADDR_W'(OFF_BASE + 2*k));
    assign attr_m[k] = (addr == ADDR_W'(OFF_ATTR + 2*k));
  end

  assign hit_cap  = (addr == ADDR_W'(OFF_CAP));
  assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign hit_sel  = (addr == ADDR_W'(OFF_SEL));
  assign hit_base = |base_m;
  assign hit_attr = |attr_m;

  always_comb begin
    a_r7_one_hit: assert ($countones({hit_cap, hit_ctrl, hit_sel, hit_base, hit_attr}) <= 1)
      else $error("R7: overlapping decode");
  end
endmodule

// File: rtl/prot_cfg_region.sv
module prot_cfg_region
  import prot_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic [BASE_W-1:0] base_in,
  input  logic [DATA_W-1:0] attr_in,
  output logic [BASE_W-1:0] base_q,
  output logic [DATA_W-1:0] attr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      attr_q <= '0;
    end else begin
      if (wr_base) base_q <= base_in;
      if (wr_attr) attr_q <= attr_in & ATTR_KEEP;
    end
  end

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_q & ~ATTR_KEEP) == '0) else $error("R6: reserved attribute bit set");

  a_r4_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base |=> $stable(base_q)) else $error("R4: base changed without write");

  a_r10_enable_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !attr_q[0]) else $error("R10: enable set after reset");
endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
  import prot_cfg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_ALIAS   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wen,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [2:0]                    cfg_ctrl,
  output logic [NUM_REGIONS*BASE_W-1:0] cfg_base,
  output logic [NUM_REGIONS*DATA_W-1:0] cfg_attr
);
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic hit_cap, hit_ctrl, hit_sel, hit_base, hit_attr;

  prot_cfg_decode #(.ADDR_W(ADDR_W), .NUM_ALIAS(NUM_ALIAS)) u_decode (
    .addr     (bus_addr),
    .hit_cap  (hit_cap),
    .hit_ctrl (hit_ctrl),
    .hit_sel  (hit_sel),
    .hit_base (hit_base),
    .hit_attr (hit_attr)
  );

  logic [SEL_W-1:0] sel_q;
  logic [2:0]       ctrl_q;

  // Named write events
  logic             base_valid;
  logic [SEL_W-1:0] base_tgt;
  logic             sel_wr_ok;
  logic             base_wr_ok;
  logic             retarget;
  logic             attr_wr;

  assign base_valid = bus_wdata[4];
  assign base_tgt   = base_valid ? {4'b0000, bus_wdata[3:0]} : sel_q;
  assign sel_wr_ok  = bus_wen && hit_sel && region_ok(bus_wdata[SEL_W-1:0], NUM_REGIONS);
  assign base_wr_ok = bus_wen && hit_base && region_ok(base_tgt, NUM_REGIONS);
  assign retarget   = base_wr_ok && base_valid;
  assign attr_wr    = bus_wen && hit_attr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (bus_wen && hit_ctrl) ctrl_q <= bus_wdata[2:0];
      if (sel_wr_ok)           sel_q  <= bus_wdata[SEL_W-1:0];
      else if (retarget)       sel_q  <= base_tgt;
    end
  end

  logic [BASE_W-1:0] base_arr [NUM_REGIONS];
  logic [DATA_W-1:0] attr_arr [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic wr_b, wr_a;
    assign wr_b = base_wr_ok && (base_tgt == SEL_W'(r));
    assign wr_a = attr_wr && (sel_q == SEL_W'(r));

    prot_cfg_region u_region (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (wr_b),
      .wr_attr (wr_a),
      .base_in (bus_wdata[31:5]),
      .attr_in (bus_wdata),
      .base_q  (base_arr[r]),
      .attr_q  (attr_arr[r])
    );

    assign cfg_base[r*BASE_W +: BASE_W] = base_arr[r];
    assign cfg_attr[r*DATA_W +: DATA_W] = attr_arr[r];
  end

  assign cfg_ctrl = ctrl_q;

  logic [RIDX_W-1:0] sel_idx;
  assign sel_idx = sel_q[RIDX_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (hit_cap)       bus_rdata = cap_word(NUM_REGIONS);
    else if (hit_ctrl) bus_rdata = {29'b0, ctrl_q};
    else if (hit_sel)  bus_rdata = {24'b0, sel_q};
    else if (hit_base) bus_rdata = base_word(base_arr[sel_idx], sel_q);
    else if (hit_attr) bus_rdata = attr_arr[sel_idx];
  end

  a_r3_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_REGIONS) else $error("R3: selector out of range");

  a_r5_retarget: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && hit_base && bus_wdata[4] && (32'(bus_wdata[3:0]) < NUM_REGIONS))
      |=> (sel_q == {4'b0000, $past(bus_wdata[3:0])}))
    else $error("R5: selector not retargeted");

  a_r9_sel_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && hit_sel && (32'(bus_wdata[7:0]) >= NUM_REGIONS)) |=> $stable(sel_q))
    else $error("R9: out-of-range selector accepted");

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wen && hit_ctrl) |=> $stable(ctrl_q)) else $error("R2: control changed without write");

  a_r10_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ctrl_q == 3'b000 && sel_q == '0)) else $error("R10: state not cleared");
endmodule

// File: tb/test_prot_cfg_regs.sv
module test_prot_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int AW = 4;
  localparam logic [31:0] KEEP = 32'h173F_FF3F;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wen = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [2:0]      cfg_ctrl;
  logic [NR*27-1:0] cfg_base;
  logic [NR*32-1:0] cfg_attr;

  int checks = 0;
  int fails = 0;

  logic [26:0] m_base [NR];
  logic [31:0] m_attr [NR];
  logic [7:0]  m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_cfg_regs #(.NUM_REGIONS(NR), .ADDR_W(AW), .NUM_ALIAS(3)) i_prot_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_ctrl(cfg_ctrl),
    .cfg_base(cfg_base), .cfg_attr(cfg_attr)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic chk_exports(string req);
    for (int r = 0; r < NR; r++) begin
      chk(req, {5'b0, cfg_base[r*27 +: 27]}, {5'b0, m_base[r]});
      chk(req, cfg_attr[r*32 +: 32], m_attr[r]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NR; r++) begin m_base[r] = '0; m_attr[r] = '0; end
    m_sel = 0;

    // Reset state
    rd(0, d); chk("R1 cap", d, 32'(NR) << 8);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R1 cap write ignored", d, 32'(NR) << 8);
    rd(1, d); chk("R10 ctrl reset", d, 0);
    rd(2, d); chk("R10 sel reset", d, 0);
    for (int r = 0; r < NR; r++) chk("R10 enable reset", {31'b0, cfg_attr[r*32]}, 0);

    // Control
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 ctrl mask", d, 7);
    chk("R2 cfg_ctrl", {29'b0, cfg_ctrl}, 7);
    wr(1, 32'h0000_0002); rd(1, d); chk("R2 ctrl value", d, 2);

    // Unmapped offsets
    for (int a = 11; a < 16; a++) begin
      wr(a, 32'hFFFF_FFFF); rd(a, d); chk("R11 unmapped read", d, 0);
    end
    rd(1, d); chk("R11 ctrl untouched", d, 2);
    rd(2, d); chk("R11 sel untouched", d, 0);

    // Sweep every region through every alias pair
    for (int r = 0; r < NR; r++) begin
      int k = r % 4;
      int kb = (k + 1) % 4;
      logic [31:0] pat;
      logic [31:0] bw;
      wr(2, 32'(r)); m_sel = 8'(r);
      rd(2, d); chk("R3 sel store", d, 32'(r));
      pat = 32'hFFFF_FFFF ^ (32'(r) * 32'h0101_0101);
      wr(4 + 2*k, pat); m_attr[r] = pat & KEEP;
      bw = 32'h1000_0000 + (32'(r) << 12) + 32'h0000_0AE0 + 32'h0000_000F;
      wr(3 + 2*k, bw); m_base[r] = bw[31:5];
      rd(4 + 2*kb, d); chk("R7 R6 attr via alias", d, pat & KEEP);
      rd(3 + 2*kb, d); chk("R7 R4 base via alias", d, {bw[31:5], 1'b0, 4'(r)});
    end
    chk_exports("R8 exports after sweep");

    // Valid-flag retarget
    wr(3, 32'hABCD_E000 | 32'h10 | 32'h2); m_base[2] = 27'(32'hABCD_E000 >> 5); m_sel = 2;
    rd(2, d); chk("R5 sel retarget", d, 2);
    rd(3, d); chk("R5 base readback", d, {m_base[2], 1'b0, 4'd2});
    wr(9, 32'h5555_4000 | 32'h10 | 32'h5); m_base[5] = 27'(32'h5555_4000 >> 5); m_sel = 5;
    rd(10, d); chk("R5 alias retarget attr", d, m_attr[5]);
    rd(2, d); chk("R5 alias retarget sel", d, 5);
    chk_exports("R5 exports");

    // Out-of-range writes
    for (int v = NR; v < 16; v++) begin
      wr(2, 32'(v)); rd(2, d); chk("R9 sel ignore", d, 32'(m_sel));
    end
    wr(2, 32'd200); rd(2, d); chk("R9 sel ignore 200", d, 32'(m_sel));
    wr(3, 32'hFFFF_FF00 | 32'h10 | 32'h9); rd(2, d); chk("R9 base valid ignore sel", d, 32'(m_sel));
    wr(7, 32'hFFFF_FF00 | 32'h10 | 32'hF); rd(2, d); chk("R9 alias valid ignore sel", d, 32'(m_sel));
    chk_exports("R9 bases untouched");

    // Enable everything, then reset
    for (int r = 0; r < NR; r++) begin
      wr(2, 32'(r)); wr(6, 32'h0000_0001);
    end
    wr(1, 32'h5);
    chk("R8 enable export", {31'b0, cfg_attr[(NR-1)*32]}, 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1, d); chk("R10 ctrl cleared", d, 0);
    rd(2, d); chk("R10 sel cleared", d, 0);
    for (int r = 0; r < NR; r++) chk("R10 enable cleared", {31'b0, cfg_attr[r*32]}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule